// File: doc/BRIEF.md
# Shared-Counter Wilkinson Conversion Latch

This block is the digital half of a many-channel ramp-down (Wilkinson) converter. Every channel discharges a storage capacitor with a constant current. The discharge ends when a comparator sees the voltage cross zero. In this model the comparators arrive as asynchronous digital levels on `cmp_i`. One 13-bit counter is shared by all channels. It steps in Gray code, so only one bit changes at each step. A channel's result is the counter value at the moment its own comparator edge arrives.

A data cycle is started with a one-cycle `start_i` pulse. It runs four passes, one for each storage bucket. All channels are converted together in every pass. At the end of each pass the captured Gray values are decoded to binary and written into a result store under that pass's bucket index. A channel that never crossed zero during a pass gets the full-scale code and an overflow flag instead. After the fourth pass `done_o` goes high, and software-side logic reads the results through a combinational bucket/channel read port.

Top module: `wilk_adc_latch`

## Requirements
- R1: After reset the outputs are `busy_o`=0, `done_o`=0 and `count_o`=0, and every bucket/channel entry reads data 0 with overflow 0.
- R2: A `start_i` pulse sampled while idle or done starts pass 0. In the first cycle after that edge, `busy_o`=1, `pass_o`=0 and `count_o`=0.
- R3: In pass cycle c (c = 0 for the first cycle of a pass), `count_o` equals the 13-bit Gray code of c, which is c XOR (c>>1). Consecutive values differ in exactly one bit. The last cycle of a pass is c=8191, where the code is 0x1000.
- R4: If `cmp_i[k]` rises before the clock edge that ends pass cycle c, and was low for at least two cycles before that, the stored result for channel k is c+2. This accounts for a two-flop synchroniser. A result captured in cycle 8191 is still stored for that pass.
- R5: Only the first rising edge of a channel within a pass is captured. Later edges in the same pass leave the stored result unchanged.
- R6: A channel with no captured edge in a pass stores 8191 (all ones) with its overflow flag set to 1. A channel that captured an edge has its overflow flag at 0.
- R7: Results are stored and read in plain binary, decoded from the captured Gray value.
- R8: Pass k (k = 0..3) writes bucket k, and `pass_o` shows k during it. Each new pass restarts the counter at 0, so every pass lasts exactly 8192 cycles.
- R9: In the cycle after pass 3 ends, `done_o`=1 and `busy_o`=0. `done_o` stays high until the next accepted `start_i`, which clears it.
- R10: `start_i` pulses while `busy_o`=1 are ignored. The count and the pass index continue undisturbed.
- R11: A comparator that is already high when a pass begins, and stays high, produces no capture in that pass. It reads as overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a four-pass data cycle when not busy |
| cmp_i | input | N_CH | Asynchronous zero-crossing comparator levels, one per channel |
| rd_bkt_i | input | 2 | Read bucket index |
| rd_ch_i | input | clog2(N_CH) | Read channel index |
| busy_o | output | 1 | Conversion passes in progress |
| done_o | output | 1 | All four buckets written |
| pass_o | output | 2 | Current pass / bucket index |
| count_o | output | 13 | Shared Gray-coded count |
| rd_data_o | output | 13 | Binary result of the addressed entry |
| rd_ovf_o | output | 1 | Overflow flag of the addressed entry |

## Verification
Faults in the shared counter show up on `count_o` within one cycle. They also show up as wrong codes in every channel of the pass in which they occur. A wrong Gray-to-binary decode only shows up after the pass commits, so the bench reads back every bucket and channel at the end of each data cycle. Targets are chosen so that the low and high bits are both exercised. A fault in the per-channel first-edge capture or in edge detection is visible only in the affected channel's entry, and only at readback. The bench therefore drives repeated pulses, channels held high across pass boundaries, and captures in the final cycle of a pass. Sequencing errors show on `pass_o`, `busy_o` and `done_o` at pass boundaries, which the bench samples in the first cycle of each pass.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
  localparam int CNT_W = 13;
  typedef logic [CNT_W-1:0] code_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_st_e;

  function automatic code_t bin2gray(code_t b);
    return b ^ (b >> 1);
  endfunction

  // prefix XOR from the MSB down
  function automatic code_t gray2bin(code_t g);
    code_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/wilk_gray_cnt.sv
module wilk_gray_cnt
  import wilk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  en_i,
  output code_t gray_o,
  output logic  term_o
);
  localparam code_t TERM_G = {1'b1, {(CNT_W-1){1'b0}}};

  code_t g_q;
  code_t g_nxt;

  assign g_nxt  = bin2gray(code_t'(gray2bin(g_q) + code_t'(1)));
  assign term_o = (g_q == TERM_G);
  assign gray_o = g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    g_q <= '0;
    else if (clr_i) g_q <= '0;
    else if (en_i)  g_q <= g_nxt;
  end

  a_r3_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> ($countones(gray_o ^ $past(gray_o)) == 1));

  a_r8_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (gray_o == '0));
endmodule

// File: rtl/wilk_seq.sv
module wilk_seq
  import wilk_pkg::*;
#(
  parameter int N_BKT = 4,
  parameter int BKT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BKT_W-1:0] pass_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             commit_o
);
  localparam logic [BKT_W-1:0] LAST = BKT_W'(N_BKT - 1);

  seq_st_e          st_q;
  logic [BKT_W-1:0] pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pass_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: if (term_i) begin
          if (pass_q == LAST) st_q <= ST_DONE;
          else                pass_q <= pass_q + BKT_W'(1);
        end
        default: if (start_i) begin
          st_q   <= ST_RUN;
          pass_q <= '0;
        end
      endcase
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = (st_q == ST_DONE);
  assign pass_o    = pass_q;
  assign commit_o  = busy_o & term_i;
  assign cnt_en_o  = busy_o;
  assign cnt_clr_o = ~busy_o | term_i;

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !term_i) |=> (busy_o && $stable(pass_o)));

  a_r8_pass_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && pass_o != LAST) |=> (busy_o && pass_o == $past(pass_o) + BKT_W'(1)));

  a_r9_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && pass_o == LAST) |=> (done_o && !busy_o));
endmodule

// File: rtl/wilk_chan.sv
module wilk_chan
  import wilk_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmp_i,
  input  logic  arm_i,
  input  logic  clr_i,
  input  code_t gray_i,
  output code_t val_o,
  output logic  hit_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            hit_q;
  code_t           cap_q;
  logic            rise;
  logic            take;

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign take = arm_i & rise & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      hit_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cmp_i};
      prev_q <= sync_q[SYNC-1];
      hit_q  <= clr_i ? 1'b0 : (hit_q | take);
      if (take) cap_q <= gray_i;
    end
  end

  // capture in the terminal cycle bypasses straight to the commit
  assign val_o = take ? gray_i : cap_q;
  assign hit_o = hit_q | take;

  a_r5_first_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && !clr_i) |=> $stable(cap_q));

  a_r11_no_rise_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sync_q[SYNC-1]) && sync_q[SYNC-1]) |-> !take);
endmodule

// File: rtl/wilk_store.sv
module wilk_store
  import wilk_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_BKT = 4,
  parameter int BKT_W = 2,
  parameter int CH_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [BKT_W-1:0]           bkt_i,
  input  logic [N_CH-1:0][CNT_W-1:0] gray_i,
  input  logic [N_CH-1:0]            hit_i,
  input  logic [BKT_W-1:0]           rd_bkt_i,
  input  logic [CH_W-1:0]            rd_ch_i,
  output code_t                      rd_data_o,
  output logic                       rd_ovf_o
);
  logic [N_BKT-1:0][N_CH-1:0][CNT_W-1:0] data_q;
  logic [N_BKT-1:0][N_CH-1:0]            ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ovf_q  <= '0;
    end else if (we_i) begin
      for (int c = 0; c < N_CH; c++) begin
        data_q[bkt_i][c] <= hit_i[c] ? gray2bin(gray_i[c]) : '1;
        ovf_q[bkt_i][c]  <= ~hit_i[c];
      end
    end
  end

  assign rd_data_o = data_q[rd_bkt_i][rd_ch_i];
  assign rd_ovf_o  = ovf_q[rd_bkt_i][rd_ch_i];

  a_r6_ovf_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovf_o |-> (&rd_data_o));
endmodule

// File: rtl/wilk_adc_latch.sv
module wilk_adc_latch
  import wilk_pkg::*;
#(
  parameter  int N_CH  = 8,
  parameter  int N_BKT = 4,
  parameter  int SYNC  = 2,
  localparam int BKT_W = (N_BKT > 1) ? $clog2(N_BKT) : 1,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_CH-1:0]  cmp_i,
  input  logic [BKT_W-1:0] rd_bkt_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BKT_W-1:0] pass_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_ovf_o
);
  logic  cnt_clr, cnt_en, term, commit;
  code_t gray;
  logic [N_CH-1:0][CNT_W-1:0] ch_val;
  logic [N_CH-1:0]            ch_hit;

  wilk_seq #(.N_BKT(N_BKT), .BKT_W(BKT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .term_i    (term),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .commit_o  (commit)
  );

  wilk_gray_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .gray_o (gray),
    .term_o (term)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    wilk_chan #(.SYNC(SYNC)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmp_i  (cmp_i[k]),
      .arm_i  (busy_o),
      .clr_i  (commit),
      .gray_i (gray),
      .val_o  (ch_val[k]),
      .hit_o  (ch_hit[k])
    );
  end

  wilk_store #(.N_CH(N_CH), .N_BKT(N_BKT), .BKT_W(BKT_W), .CH_W(CH_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (commit),
    .bkt_i     (pass_o),
    .gray_i    (ch_val),
    .hit_i     (ch_hit),
    .rd_bkt_i  (rd_bkt_i),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o),
    .rd_ovf_o  (rd_ovf_o)
  );

  assign count_o = gray;
endmodule

// File: tb/wilk_adc_latch_bench.sv
module wilk_adc_latch_bench;
  localparam int T_CLK = 10;
  localparam int NCH   = 8;
  localparam int NB    = 4;
  localparam int LASTC = 8191;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [NCH-1:0] cmp_i = '0;
  logic [1:0]  rd_bkt_i = '0;
  logic [2:0]  rd_ch_i = '0;
  logic        busy_o, done_o, rd_ovf_o;
  logic [1:0]  pass_o;
  logic [12:0] count_o, rd_data_o;

  int n_vec = 0;
  int n_bad = 0;
  int tgt [NB][NCH];  // >=3 target, -1 stays low, -2 left as is (held)
  bit dbl [NCH];

  always #(T_CLK/2) clk_i = ~clk_i;

  wilk_adc_latch u_wilk_adc_latch (
    .clk_i, .rst_ni, .start_i, .cmp_i, .rd_bkt_i, .rd_ch_i,
    .busy_o, .done_o, .pass_o, .count_o, .rd_data_o, .rd_ovf_o
  );

  function automatic int gray(int b);
    return (b ^ (b >> 1)) & 13'h1fff;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 count", count_o, 0);
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < NCH; c++) begin
        rd_bkt_i = 2'(b); rd_ch_i = 3'(c); #1;
        check("R1 data", rd_data_o, 0);
        check("R1 ovf", rd_ovf_o, 0);
      end
  endtask

  task automatic readback(input string tag);
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < NCH; c++) begin
        int t = tgt[b][c];
        string req;
        rd_bkt_i = 2'(b); rd_ch_i = 3'(c); #1;
        if (t == -2)     req = "R11 held high";
        else if (t < 0)  req = "R6 no crossing";
        else if (dbl[c]) req = "R5 first edge";
        else             req = "R4 R7 R8 capture";
        check({tag, " ", req, " data"}, rd_data_o, (t >= 0) ? t : LASTC);
        check({tag, " ", req, " ovf"}, rd_ovf_o, (t >= 0) ? 0 : 1);
      end
  endtask

  task automatic run_data_cycle(input string tag, input bit poke_start);
    @(negedge clk_i);
    start_i = 1'b1;
    for (int p = 0; p < NB; p++) begin
      for (int c = 0; c <= LASTC; c++) begin
        @(negedge clk_i);
        if (p == 0 && c == 0) begin
          start_i = 1'b0;
          check("R2 R9 done cleared", done_o, 0);
        end
        if (c == 0) begin
          check("R2 R8 busy", busy_o, 1);
          check("R2 R8 pass", pass_o, p);
          check("R2 R8 count restart", count_o, 0);
        end
        if (c == 2)     check("R3 gray step", count_o, gray(2));
        if (c == 1234)  check("R3 gray mid", count_o, gray(1234));
        if (c == LASTC) check("R3 terminal", count_o, 13'h1000);
        if (poke_start && p == 1) begin
          if (c == 500) start_i = 1'b1;
          if (c == 501) begin
            start_i = 1'b0;
            check("R10 count kept", count_o, gray(501));
            check("R10 pass kept", pass_o, 1);
          end
        end
        for (int k = 0; k < NCH; k++) begin
          int t = tgt[p][k];
          if (c == 0 && t != -2) cmp_i[k] = 1'b0;
          if (t >= 0) begin
            if (c == t - 2) cmp_i[k] = 1'b1;
            if (dbl[k] && c == t + 4)  cmp_i[k] = 1'b0;
            if (dbl[k] && c == t + 18) cmp_i[k] = 1'b1;
          end
        end
      end
    end
    @(negedge clk_i);
    check("R9 done", done_o, 1);
    check("R9 idle", busy_o, 0);
    readback(tag);
    repeat (10) @(negedge clk_i);
    check("R9 done held", done_o, 1);
  endtask

  task automatic t_patterns;
    for (int p = 0; p < NB; p++)
      for (int k = 0; k < NCH; k++) tgt[p][k] = 3 + 500 * k + 900 * p;
    tgt[2][5] = -1;
    tgt[3][0] = LASTC;   // capture in the terminal cycle
    tgt[1][2] = LASTC - 1;
    tgt[0][3] = 4095;
    for (int k = 0; k < NCH; k++) dbl[k] = 1'b0;
    run_data_cycle("patterns", 1'b0);
  endtask

  task automatic t_repeat_hold_busy;
    for (int p = 0; p < NB; p++)
      for (int k = 0; k < NCH; k++) tgt[p][k] = 40 + 211 * k + 17 * p + 2000 * p;
    tgt[0][7] = 60;
    for (int p = 1; p < NB; p++) tgt[p][7] = -2;
    tgt[1][6] = -1;
    for (int k = 0; k < NCH; k++) dbl[k] = 1'b1;
    run_data_cycle("repeat_hold", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_patterns();
    t_repeat_hold_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule